// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block multiplies two N-bit two's-complement operands and returns their exact 2N-bit signed product in a single combinational pass. N must be even. The multiplier operand is scanned in overlapping three-bit windows. Each window becomes one partial product, so the array holds N/2 rows instead of N. Every row is a choice among zero, plus or minus the multiplicand, and plus or minus twice the multiplicand. No row ever needs three times the multiplicand.

A control stage recodes the multiplier into a small strobe record for each row: a one-times select, a two-times select and a negate flag. The datapath uses these strobes to steer each multiplicand bit. A negated row is formed by inverting its bits, and the missing +1 goes into a separate injection word. The sign of each row is handled by flipping its top bit and adding one constant that is computed at elaboration. All rows, the injection word and the constant are folded by a chain of 3:2 carry-save stages. A single carry-propagate add then gives the product.

Top module: `booth_mul`

## Requirements
- R1: For every pair of N-bit two's-complement operands, `product` equals their exact signed product as a 2N-bit two's-complement value.
- R2: When either operand is zero, `product` is zero.
- R3: The most negative operand times the most negative operand gives 2^(2N-2), which is positive, in `product`.
- R4: For each recoding window, the one-times and two-times selects are never both active.
- R5: The negate flag of a window is set only when a nonzero magnitude is selected. Windows 000 and 111 select zero. With an all-ones multiplier, the product is the negated multiplicand.
- R6: Window 100 (bits 2i+1, 2i, 2i-1, with bit -1 taken as 0) selects minus twice the multiplicand. A multiplier of 2 therefore gives twice the multiplicand.
- R7: Each carry-save stage keeps the sum of its three inputs modulo 2^(2N). Its carry vector has double weight, and the bit leaving position 2N-1 is discarded.
- R8: A row with no magnitude selected has every one of its N+1 bits equal to its negate flag.
- R9: Products with a negative result are correct, for example the most negative operand times 1, and the most positive operand times the most negative operand. This shows that the precomputed sign constant stands in for full sign extension.
- R10: Carries out of bit 2N-1 in the final add are dropped, so (-1) times (-1) gives exactly 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opMultiplier | input | N | Two's-complement multiplier, recoded in three-bit windows |
| opMultiplicand | input | N | Two's-complement multiplicand, steered into each row |
| product | output | 2N | Signed product |

## Verification
The embedded checks assume that the operand inputs are settled, two-state values whenever a combinational block evaluates. They also assume that N is even and at least 2, so that every window and every row position exists. The stimulus drives both operands together on one clock edge and holds them steady until the next. The outputs are compared on the opposite edge. The width is fixed at 8 for the exhaustive sweep and at 16 for the random and corner vectors.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // Strobes handed from the recoder to the datapath, one record per row.
  typedef struct packed {
    logic selOne;   // take the multiplicand once
    logic selTwo;   // take the multiplicand shifted left by one
    logic negate;   // invert the row and inject +1 at its weight
  } boothSel_t;

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0]                  mulX,
  output boothSel_t [N/2-1:0]           selVec
);

  localparam int ROWS = N / 2;

  // Multiplier with an implied zero below bit 0.
  logic [N:0] xExt;
  assign xExt = {mulX, 1'b0};

  for (genvar i = 0; i < ROWS; i++) begin : g_window
    logic [2:0] grp;
    boothSel_t  sel;

    assign grp = xExt[2*i+2 : 2*i];

    always_comb begin
      sel = '0;
      unique case (grp)
        3'b000, 3'b111: sel = '0;
        3'b001, 3'b010: sel = '{selOne: 1'b1, selTwo: 1'b0, negate: 1'b0};
        3'b011:         sel = '{selOne: 1'b0, selTwo: 1'b1, negate: 1'b0};
        3'b100:         sel = '{selOne: 1'b0, selTwo: 1'b1, negate: 1'b1};
        default:        sel = '{selOne: 1'b1, selTwo: 1'b0, negate: 1'b1};
      endcase

      // R4: a window picks one magnitude at most
      p_one_magnitude_r4: assert (!(sel.selOne && sel.selTwo))
        else $error("window %0d selects both magnitudes", i);
      // R5: a negated row always carries a nonzero magnitude
      p_neg_nonzero_r5: assert (!sel.negate || sel.selOne || sel.selTwo)
        else $error("window %0d negates a zero row", i);
    end

    assign selVec[i] = sel;
  end

endmodule

// File: rtl/booth_csa_row.sv
module booth_csa_row #(
  parameter int W = 32
) (
  input  logic [W-1:0] inA,
  input  logic [W-1:0] inB,
  input  logic [W-1:0] inC,
  output logic [W-1:0] sumOut,
  output logic [W-1:0] carryOut
);

  logic [W-1:0] maj;

  always_comb begin
    sumOut   = inA ^ inB ^ inC;
    maj      = (inA & inB) | (inA & inC) | (inB & inC);
    carryOut = {maj[W-2:0], 1'b0};

    // R7: the compressor keeps the modular sum of its inputs
    p_csa_keeps_sum_r7: assert (W'(sumOut + carryOut) == W'(inA + inB + inC))
      else $error("3:2 stage lost its sum");
  end

endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
  import booth_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0]        mulY,
  input  boothSel_t [N/2-1:0] selVec,
  output logic [2*N-1:0]      product
);

  localparam int ROWS   = N / 2;
  localparam int W      = 2 * N;
  localparam int WORDS  = ROWS + 2;      // rows, +1 injection word, sign constant
  localparam int STAGES = WORDS - 2;

  // Sum of -2^(N+2i) over all rows: replaces every row's sign extension.
  function automatic logic [W-1:0] signConst();
    logic [W-1:0] acc;
    acc = '0;
    for (int i = 0; i < ROWS; i++) begin
      acc = acc - (W'(1) << (N + 2 * i));
    end
    return acc;
  endfunction

  localparam logic [W-1:0] SIGN_K = signConst();

  // yExt[j+1] is y[j] for j in 0..N (with y[N] = y[N-1]); yExt[j] is y[j-1].
  logic [N+1:0] yExt;
  assign yExt = {mulY[N-1], mulY, 1'b0};

  logic [WORDS-1:0][W-1:0] words;
  logic [ROWS-1:0]         negBits;

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    logic [N:0]   ppBits;
    logic [W-1:0] rowWord;

    always_comb begin
      for (int j = 0; j <= N; j++) begin
        ppBits[j] = ((selVec[i].selOne & yExt[j+1]) |
                     (selVec[i].selTwo & yExt[j])) ^ selVec[i].negate;
      end
      rowWord = '0;
      rowWord[2*i +: N] = ppBits[N-1:0];
      rowWord[2*i + N]  = ~ppBits[N];

      // R8: an empty row is all copies of its negate flag
      p_zero_row_r8: assert (selVec[i].selOne || selVec[i].selTwo ||
                             ppBits == {(N+1){selVec[i].negate}})
        else $error("row %0d not flat with no magnitude", i);
    end

    assign words[i]   = rowWord;
    assign negBits[i] = selVec[i].negate;
  end

  // Injection word: each row's +1 sits at bit 2i.
  logic [W-1:0] injWord;
  always_comb begin
    injWord = '0;
    for (int i = 0; i < ROWS; i++) begin
      injWord[2*i] = negBits[i];
    end
  end

  assign words[ROWS]     = injWord;
  assign words[ROWS + 1] = SIGN_K;

  // Linear carry-save chain: WORDS-2 stages.
  logic [STAGES-1:0][W-1:0] sumV;
  logic [STAGES-1:0][W-1:0] carV;

  for (genvar s = 0; s < STAGES; s++) begin : g_csa
    if (s == 0) begin : g_first
      booth_csa_row #(.W(W)) i_csa (
        .inA      (words[0]),
        .inB      (words[1]),
        .inC      (words[2]),
        .sumOut   (sumV[s]),
        .carryOut (carV[s])
      );
    end else begin : g_next
      booth_csa_row #(.W(W)) i_csa (
        .inA      (sumV[s-1]),
        .inB      (carV[s-1]),
        .inC      (words[s+2]),
        .sumOut   (sumV[s]),
        .carryOut (carV[s])
      );
    end
  end

  // Final carry-propagate add; the carry past bit W-1 is discarded.
  assign product = sumV[STAGES-1] + carV[STAGES-1];

endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0]   opMultiplier,
  input  logic [N-1:0]   opMultiplicand,
  output logic [2*N-1:0] product
);

  localparam int ROWS = N / 2;

  boothSel_t [ROWS-1:0] selVec;

  booth_recoder #(.N(N)) i_recoder (
    .mulX   (opMultiplier),
    .selVec (selVec)
  );

  booth_datapath #(.N(N)) i_datapath (
    .mulY    (opMultiplicand),
    .selVec  (selVec),
    .product (product)
  );

endmodule

// File: tb/test_booth_mul.sv
module test_booth_mul;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 4 ns period
  logic rstN = 1'b0;

  logic [7:0]  xa = '0, ya = '0;
  logic [15:0] pa;
  logic [15:0] xb = '0, yb = '0;
  logic [31:0] pb;

  booth_mul #(.N(8)) i_booth_mul (
    .opMultiplier   (xa),
    .opMultiplicand (ya),
    .product        (pa)
  );

  booth_mul #(.N(16)) i_booth_mul_wide (
    .opMultiplier   (xb),
    .opMultiplicand (yb),
    .product        (pb)
  );

  typedef struct {
    string       tag;
    logic [7:0]  xa, ya;
    logic [15:0] ea;
    logic [15:0] xb, yb;
    logic [31:0] eb;
  } item_t;

  item_t q[$];
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  task automatic drive(input string tag, input logic [7:0] a, input logic [7:0] b,
                       input logic [15:0] c, input logic [15:0] d);
    item_t it;
    logic signed [15:0] expA;
    logic signed [31:0] expB;
    expA = $signed(a) * $signed(b);
    expB = $signed(c) * $signed(d);
    @(posedge clk);
    xa = a; ya = b; xb = c; yb = d;
    it.tag = tag; it.xa = a; it.ya = b; it.ea = expA;
    it.xb = c; it.yb = d; it.eb = expB;
    q.push_back(it);
  endtask

  // Monitor: compares on the falling edge after each drive.
  always @(negedge clk) begin
    if (rstN && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      nChecks += 2;
      if (pa !== it.ea) begin
        nFails++;
        $display("FAIL %s narrow x=%h y=%h got %h expected %h", it.tag, it.xa, it.ya, pa, it.ea);
      end
      if (pb !== it.eb) begin
        nFails++;
        $display("FAIL %s wide x=%h y=%h got %h expected %h", it.tag, it.xb, it.yb, pb, it.eb);
      end
    end
  end

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // R2: idle inputs right after reset, then a zero operand on each side
    drive("R2 reset idle", 8'h00, 8'h00, 16'h0000, 16'h0000);
    drive("R2 zero multiplier", 8'h00, 8'h5A, 16'h0000, 16'hBEEF);
    drive("R2 zero multiplicand", 8'hA7, 8'h00, 16'h9C3D, 16'h0000);
    // R3: most negative squared
    drive("R3 min times min", 8'h80, 8'h80, 16'h8000, 16'h8000);
    // R5: all-ones multiplier negates the multiplicand
    drive("R5 all ones multiplier", 8'hFF, 8'h37, 16'hFFFF, 16'h1234);
    // R6: window 100 gives -2Y, then +Y in the next window
    drive("R6 multiplier two", 8'h02, 8'h35, 16'h0002, 16'h4321);
    drive("R6 alternating", 8'hAA, 8'h6B, 16'hAAAA, 16'h7001);
    // R9: negative results rely on the sign constant
    drive("R9 min times one", 8'h80, 8'h01, 16'h8000, 16'h0001);
    drive("R9 max times min", 8'h7F, 8'h80, 16'h7FFF, 16'h8000);
    drive("R9 min times max", 8'h80, 8'h7F, 16'h8000, 16'h7FFF);
    // R10: carries beyond the top bit are dropped
    drive("R10 minus one squared", 8'hFF, 8'hFF, 16'hFFFF, 16'hFFFF);
    // R1 R4 R7 R8: exhaustive narrow sweep, random wide operands alongside
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        drive("R1 R4 R7 R8 sweep", 8'(a), 8'(b), 16'($urandom), 16'($urandom));
      end
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired with %0d items pending", q.size());
      finishRun();
    end
  end

endmodule